// File: doc/BRIEF.md
# Latched-Status Interrupt Bank

A bank of eight interrupt channels. Each channel watches one input. A type bit and a polarity bit decide what counts as a qualifying condition: a level or an edge, active high or active low. Every channel has a hidden latch that software cannot read. The latch records a qualifying condition even while the channel is disabled. A disabled channel changes nothing else and sends no notification.

When a channel is enabled with its hidden latch set, the pending condition moves into the readable status register and a notification is raised. Software that wants to discard conditions seen while the channel was off first writes the channel's bit in the clear register. It can also use the arm register, which clears and enables in one write. Software reads back the enable register to learn whether a channel is already on before it touches clear or enable.

Notifications leave on a valid/ready stream that carries a channel index. Each channel has one pending slot. While the stream is idle, the lowest-numbered pending channel is offered first. An offer stays in place until it is accepted. A transfer happens on a cycle where both `ntf_valid` and `ntf_ready` are high. While `ntf_ready` is low, `ntf_valid` stays high and `ntf_chan` does not change, even when a lower channel becomes pending. New notifications are still collected in their per-channel slots during that time.

Top module: `lsirq_bank`

## Requirements
- R1: After reset, the type, enable and status registers read 0x00, the polarity register reads 0xFF, and `ntf_valid` is low.
- R2: Register addresses: 0 = type, 1 = polarity, 2 = enable (all read/write); 3 = status (read-only, writes ignored); 4 = clear and 5 = arm (write-only, read 0x00); every other address reads 0x00. Bit i of each register belongs to channel i.
- R3: With type bit 0 (level), a channel qualifies on every cycle in which its input equals its polarity bit (1 = active high, 0 = active low).
- R4: With type bit 1 (edge), a channel qualifies only on the cycle where its input differs from the value sampled one cycle earlier in the selected direction (polarity 1 = rising, 0 = falling). A steady input never qualifies again.
- R5: A qualifying condition on a disabled channel sets only its hidden latch. Status and the notification stream stay unchanged.
- R6: Writing the enable register with a 1 for a channel whose hidden latch is set sets that status bit and queues a notification. Both are visible in the cycle after the write.
- R7: On an enabled channel, a qualifying input sampled at a clock edge sets the status bit and queues a notification. Both are visible right after that edge.
- R8: Writing 1 to bit i of the clear register clears channel i's hidden latch and status bit. Zero bits have no effect. The clear wins over a condition in the same cycle, so a later enable produces no notification.
- R9: Writing bit i of the arm register clears channel i's hidden latch and status and sets its enable bit, all in one cycle. No notification results from conditions seen before that write.
- R10: The notification stream holds one pending entry per channel. When no offer is being held, it presents the lowest-numbered pending channel. An entry is removed when `ntf_valid` and `ntf_ready` are both high.
- R11: While `ntf_valid` is high and `ntf_ready` is low, on the next cycle `ntf_valid` stays high and `ntf_chan` is unchanged.
- R12: A status bit stays set until it is cleared. Disabling the channel does not clear it. Further conditions on that channel produce no new notification while the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw interrupt inputs, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| ntf_valid | output | 1 | Notification offered |
| ntf_ready | input | 1 | Notification accepted by the sink |
| ntf_chan | output | 3 | Index of the channel being notified |

## Verification
The latch behaviour is tried with three patterns, and each one separates the hidden latch from the status path. A condition arrives while the channel is off and is followed by a plain enable. A condition is followed by a clear and then an enable. A condition is followed by a single arm write. Level inputs held across a clear are compared with edge inputs held across a clear: a level channel would latch again, while an edge channel stays quiet. Falling-edge and active-low settings are checked against their rising and active-high counterparts. On the stream, two channels fire together while the sink stalls, and a lower channel arrives during the stall. This shows both the lowest-first ordering and that a held offer does not move.

// File: rtl/lsirq_pkg.sv
package lsirq_pkg;
  typedef enum logic [2:0] {
    RA_TYPE = 3'd0,
    RA_POL  = 3'd1,
    RA_EN   = 3'd2,
    RA_STS  = 3'd3,
    RA_CLR  = 3'd4,
    RA_ARM  = 3'd5
  } reg_addr_e;

  localparam logic [2:0] ADDR_W_CHECK = 3'd7;
endpackage

// File: rtl/lsirq_detect.sv
module lsirq_detect #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_in,
  input  logic [NCH-1:0] type_q,
  input  logic [NCH-1:0] pol_q,
  output logic [NCH-1:0] hit
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic lvl_hit;
    logic rise;
    logic fall;
    always_comb begin
      lvl_hit = (irq_in[g] == pol_q[g]);
      rise    = irq_in[g] & ~prev_q[g];
      fall    = ~irq_in[g] & prev_q[g];
      if (type_q[g]) hit[g] = pol_q[g] ? rise : fall;
      else           hit[g] = lvl_hit;
    end
  end
endmodule

// File: rtl/lsirq_regs.sv
module lsirq_regs
  import lsirq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] reg_rdata,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] type_q,
  output logic [NCH-1:0] pol_q,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] sts_q,
  output logic [NCH-1:0] notify
);
  logic [NCH-1:0] lat_q;
  logic [NCH-1:0] en_nx, lat_nx, sts_nx, clr;
  logic wr_type, wr_pol, wr_en, wr_clr, wr_arm;

  always_comb begin
    wr_type = reg_wr && (reg_addr == RA_TYPE);
    wr_pol  = reg_wr && (reg_addr == RA_POL);
    wr_en   = reg_wr && (reg_addr == RA_EN);
    wr_clr  = reg_wr && (reg_addr == RA_CLR);
    wr_arm  = reg_wr && (reg_addr == RA_ARM);

    en_nx = en_q;
    if (wr_en)  en_nx = reg_wdata;
    if (wr_arm) en_nx = en_q | reg_wdata;

    clr    = (wr_clr || wr_arm) ? reg_wdata : '0;
    lat_nx = ~clr & (lat_q | hit);
    sts_nx = ~clr & (sts_q | (lat_nx & en_nx));
    notify = sts_nx & ~sts_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= '0;
      pol_q  <= '1;
      en_q   <= '0;
      lat_q  <= '0;
      sts_q  <= '0;
    end else begin
      if (wr_type) type_q <= reg_wdata;
      if (wr_pol)  pol_q  <= reg_wdata;
      en_q  <= en_nx;
      lat_q <= lat_nx;
      sts_q <= sts_nx;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_TYPE: reg_rdata = type_q;
      RA_POL:  reg_rdata = pol_q;
      RA_EN:   reg_rdata = en_q;
      RA_STS:  reg_rdata = sts_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lsirq_notify_q.sv
module lsirq_notify_q #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] notify,
  input  logic           ntf_ready,
  output logic           ntf_valid,
  output logic [CW-1:0]  ntf_chan,
  output logic [NCH-1:0] pend_q
);
  logic          hold_q;
  logic [CW-1:0] hold_ch_q;
  logic [CW-1:0] low_ch;
  logic [NCH-1:0] pop_mask;
  logic          pop;

  always_comb begin
    low_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) low_ch = CW'(i);
    end
    ntf_valid = |pend_q;
    ntf_chan  = hold_q ? hold_ch_q : low_ch;
    pop       = ntf_valid && ntf_ready;
    pop_mask  = '0;
    if (pop) pop_mask[ntf_chan] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      hold_q    <= 1'b0;
      hold_ch_q <= '0;
    end else begin
      pend_q    <= (pend_q & ~pop_mask) | notify;
      hold_q    <= ntf_valid && !ntf_ready;
      hold_ch_q <= ntf_chan;
    end
  end
endmodule

// File: rtl/lsirq_bank.sv
module lsirq_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_in,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] reg_rdata,
  output logic           ntf_valid,
  input  logic           ntf_ready,
  output logic [CW-1:0]  ntf_chan
);
  logic [NCH-1:0] hit, type_q, pol_q, en_q, sts_q, notify, pend_q;

  lsirq_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .type_q(type_q), .pol_q(pol_q), .hit(hit)
  );

  lsirq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hit(hit),
    .type_q(type_q), .pol_q(pol_q), .en_q(en_q), .sts_q(sts_q),
    .notify(notify)
  );

  lsirq_notify_q #(.NCH(NCH), .CW(CW)) u_queue (
    .clk(clk), .rst_n(rst_n), .notify(notify), .ntf_ready(ntf_ready),
    .ntf_valid(ntf_valid), .ntf_chan(ntf_chan), .pend_q(pend_q)
  );
endmodule

// File: rtl/lsirq_bank_chk.sv
module lsirq_bank_chk
  import lsirq_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [2:0]     reg_addr,
  input logic [NCH-1:0] reg_wdata,
  input logic           ntf_valid,
  input logic           ntf_ready,
  input logic [CW-1:0]  ntf_chan,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] sts_q,
  input logic [NCH-1:0] pend_q
);
  assert_held_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_chan)));

  assert_no_status_while_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~en_q) == '0));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_CLR || reg_addr == RA_ARM))
      |=> ((sts_q & $past(reg_wdata)) == '0));

  assert_new_status_queued_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~pend_q) == '0));

  assert_offer_is_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> pend_q[ntf_chan]);
endmodule

bind lsirq_bank lsirq_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
  .ntf_chan(ntf_chan), .en_q(en_q), .sts_q(sts_q), .pend_q(pend_q)
);

// File: tb/lsirq_bank_bench.sv
module lsirq_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ntf_valid;
  logic       ntf_ready = 1'b0;
  logic [2:0] ntf_chan;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsirq_bank u_lsirq_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_chan(ntf_chan)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] wd;
    logic [7:0] irq;
    logic       rdy;
    logic [7:0] es;
    logic       ev;
    logic [2:0] ec;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd5},  // R5 idle
    '{1'b0, 3'd0, 8'h00, 8'h01, 1'b0, 8'h00, 1'b0, 3'd0, 4'd5},  // R5 ch0 fires while off
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd5},
    '{1'b1, 3'd2, 8'h01, 8'h00, 1'b0, 8'h01, 1'b1, 3'd0, 4'd6},  // R6 enable releases latch
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 3'd0, 4'd10}, // R10 pop
    '{1'b1, 3'd4, 8'h01, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd8},  // R8 clear status
    '{1'b0, 3'd0, 8'h00, 8'h04, 1'b0, 8'h00, 1'b0, 3'd0, 4'd5},  // R5 ch2 fires while off
    '{1'b1, 3'd4, 8'h04, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd8},  // R8 clear hidden
    '{1'b1, 3'd2, 8'h05, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd8},  // R8 enable: no spurious
    '{1'b0, 3'd0, 8'h00, 8'h08, 1'b0, 8'h00, 1'b0, 3'd0, 4'd5},  // ch3 fires while off
    '{1'b1, 3'd5, 8'h08, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd9},  // R9 arm
    '{1'b0, 3'd0, 8'h00, 8'h0C, 1'b0, 8'h0C, 1'b1, 3'd2, 4'd7},  // R7 two fire, lowest first
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h0C, 1'b1, 3'd2, 4'd11}, // R11 stall
    '{1'b0, 3'd0, 8'h00, 8'h01, 1'b0, 8'h0D, 1'b1, 3'd2, 4'd11}, // R11 lower arrives, held
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 8'h0D, 1'b1, 3'd0, 4'd10}, // R10 pop ch2
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 8'h0D, 1'b1, 3'd3, 4'd10}, // R10 pop ch0
    '{1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 8'h0D, 1'b0, 3'd0, 4'd10}, // R10 pop ch3
    '{1'b0, 3'd0, 8'h00, 8'h08, 1'b0, 8'h0D, 1'b0, 3'd0, 4'd12}, // R12 no renotify
    '{1'b1, 3'd2, 8'h00, 8'h00, 1'b0, 8'h0D, 1'b0, 3'd0, 4'd12}, // R12 disable keeps status
    '{1'b1, 3'd4, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 4'd8}   // R8 clear all
  };

  task automatic chk(input int req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, take one rising edge, return after the next falling edge.
  task automatic step(input logic wr, input logic [2:0] a, input logic [7:0] wd,
                      input logic [7:0] irq, input logic rdy);
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = wd;
    irq_in    = irq;
    ntf_ready = rdy;
    @(posedge clk);
    @(negedge clk);
    reg_wr   = 1'b0;
    reg_addr = 3'd3;
    #1;
  endtask

  task automatic expect_out(input int req, input logic [7:0] es, input logic ev,
                            input logic [2:0] ec);
    chk(req, "status", {24'd0, reg_rdata}, {24'd0, es});
    chk(req, "valid", {31'd0, ntf_valid}, {31'd0, ev});
    if (ev) chk(req, "chan", {29'd0, ntf_chan}, {29'd0, ec});
  endtask

  task automatic rd(input int req, input logic [2:0] a, input logic [7:0] exp);
    reg_wr   = 1'b0;
    reg_addr = a;
    #1;
    chk(req, "readback", {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    irq_in = '0;
    reg_wr = 1'b0;
    ntf_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic reset_checks();
    // R1 defaults
    rd(1, 3'd0, 8'h00);
    rd(1, 3'd1, 8'hFF);
    rd(1, 3'd2, 8'h00);
    rd(1, 3'd3, 8'h00);
    chk(1, "valid after reset", {31'd0, ntf_valid}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    reset_checks();

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].irq, VEC[i].rdy);
      expect_out(int'(VEC[i].req), VEC[i].es, VEC[i].ev, VEC[i].ec);
    end

    // Edge and active-low channels (R3, R4)
    step(1'b1, 3'd0, 8'h30, 8'h00, 1'b0);     // ch4, ch5 edge type
    step(1'b1, 3'd1, 8'hDF, 8'h00, 1'b0);     // ch5 falling
    step(1'b1, 3'd5, 8'h30, 8'h00, 1'b0);     // arm ch4, ch5
    expect_out(9, 8'h00, 1'b0, 3'd0);
    step(1'b0, 3'd0, 8'h00, 8'h30, 1'b0);     // R4 rising on ch4 only
    expect_out(4, 8'h10, 1'b1, 3'd4);
    step(1'b1, 3'd4, 8'h10, 8'h30, 1'b1);     // clear + pop, input held high
    expect_out(4, 8'h00, 1'b0, 3'd0);
    step(1'b0, 3'd0, 8'h00, 8'h30, 1'b0);     // R4 steady input: no new edge
    expect_out(4, 8'h00, 1'b0, 3'd0);
    step(1'b0, 3'd0, 8'h00, 8'h00, 1'b0);     // R4 falling on ch5
    expect_out(4, 8'h20, 1'b1, 3'd5);
    step(1'b1, 3'd1, 8'h9F, 8'h00, 1'b0);     // R3 ch6 active low, off
    step(1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
    expect_out(3, 8'h20, 1'b1, 3'd5);
    step(1'b1, 3'd2, 8'h70, 8'h00, 1'b0);     // R3 enable ch6 releases low-level latch
    expect_out(3, 8'h60, 1'b1, 3'd5);

    // Mid-run reset, then register map (R1, R2)
    do_reset();
    reset_checks();
    step(1'b1, 3'd0, 8'hA5, 8'h00, 1'b0);
    rd(2, 3'd0, 8'hA5);
    step(1'b1, 3'd2, 8'h3C, 8'h00, 1'b0);
    rd(2, 3'd2, 8'h3C);
    step(1'b1, 3'd3, 8'hFF, 8'h00, 1'b0);     // R2 status write ignored
    rd(2, 3'd3, 8'h00);
    chk(2, "valid after status write", {31'd0, ntf_valid}, 32'd0);
    step(1'b1, 3'd4, 8'h00, 8'h00, 1'b0);
    rd(2, 3'd4, 8'h00);
    rd(2, 3'd5, 8'h00);
    rd(2, 3'd6, 8'h00);
    rd(2, 3'd7, 8'h00);

    finish_run();
  end
endmodule